// File: doc/BRIEF.md
# Programmable Period Digital Oscillator

This block is a digitally controlled oscillator that runs on a fixed counter clock. It works as a down-counter with a zero detector and a subtractor that computes the reload value. Each time the count reaches zero, the block raises a pulse for one clock. On the next edge it reloads the counter so that the following period lasts `M - K` clock cycles. `M` is a fixed modulus parameter and `K` is a signed control word that normally comes from a loop filter. A larger `K` gives a shorter period, and a negative `K` gives a longer one.

The control word is read only at the reload edge, so changing it in the middle of a period has no effect until the next period starts. The computed period is clamped to the range 1 to 2M − 1. The period therefore never reaches zero and never exceeds what the counter can hold. The block also provides a square wave that flips on every pulse, which a parameter can switch off. Reset acts like a reload with a zero control word, so the first period has the free-running length.

Top module: `dco_prog_period`

## Requirements
- R1: Between reloads the internal count falls by exactly one on every rising clock edge, so a period of P produces P − 1 clock cycles with `pulse_o` low between two pulses whenever P ≥ 2.
- R2: `pulse_o` is high in exactly the cycles where the count is zero. When the current period is 2 or more, the pulse is exactly one clock cycle wide.
- R3: The number of rising edges from one `pulse_o` cycle to the next equals M − K. Here K is `ctrl_k` read as a K_W-bit two's-complement number, sampled at the edge that ends the earlier pulse.
- R4: With `ctrl_k` equal to zero, the period is M cycles, which is the counter clock frequency divided by M.
- R5: When M − K is below 1, the period becomes 1 and `pulse_o` stays high on every cycle. When M − K is above 2M − 1, the period becomes 2M − 1.
- R6: `ctrl_k` is sampled only at the reload edge. A change in the middle of a period does not alter that period's length and takes effect in the following period.
- R7: While `rst_n` is low, `pulse_o` and `square_o` are 0. The first pulse appears M rising edges after the last edge at which `rst_n` was sampled low.
- R8: `square_o` inverts on every rising edge at which `pulse_o` is high and holds its value on all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_k | input | K_W | Signed period control word |
| pulse_o | output | 1 | High for the cycle in which the count is zero |
| square_o | output | 1 | Square wave that inverts on each pulse |

## Verification
The hardest condition to reach from the ports is a control word that changes part-way through a period. The bench has to show that the running period keeps its length and that the new value governs only the next period. It does this by measuring from one pulse, changing `ctrl_k` several cycles later, and timing two consecutive intervals. The clamp edges are also hard to reach, because they need extreme control words that still count correctly. To cover them, the bench sweeps every K_W-bit control value and compares each interval with an arithmetic model, including the stretch where the pulse never goes low.

// File: rtl/dco_pkg.sv
package dco_pkg;

  // Period in counter-clock cycles for modulus m and signed control k,
  // bounded so it is never zero and never beyond 2m-1.
  function automatic int period_of(input int m, input int k);
    int d;
    d = m - k;
    if (d < 1)
      return 1;
    else if (d > 2 * m - 1)
      return 2 * m - 1;
    else
      return d;
  endfunction

  // Counter width able to hold every value the counter can take.
  function automatic int count_width(input int m);
    return $clog2(2 * m);
  endfunction

endpackage

// File: rtl/dco_reload_calc.sv
module dco_reload_calc #(
  parameter int MOD_M = 16,
  parameter int K_W   = 6,
  parameter int CNT_W = 5
) (
  input  logic signed [K_W-1:0]   k_in,
  output logic        [CNT_W-1:0] period,
  output logic        [CNT_W-1:0] load_val,
  output logic                    clip_lo,
  output logic                    clip_hi
);
  localparam int DW    = ((K_W > CNT_W) ? K_W : CNT_W) + 3;
  localparam int P_MAX = 2 * MOD_M - 1;

  logic signed [DW-1:0] m_ext;
  logic signed [DW-1:0] k_ext;
  logic signed [DW-1:0] diff;

  always_comb begin
    m_ext   = DW'(MOD_M);
    k_ext   = DW'(k_in);
    diff    = m_ext - k_ext;
    clip_lo = (diff < DW'(1));
    clip_hi = (diff > DW'(P_MAX));
    if (clip_lo)
      period = CNT_W'(1);
    else if (clip_hi)
      period = CNT_W'(P_MAX);
    else
      period = diff[CNT_W-1:0];
    load_val = period - CNT_W'(1);
  end

  // R5: the computed period always stays within the legal window
  always_comb begin
    a_range_r5: assert (period >= CNT_W'(1) && period <= CNT_W'(P_MAX))
      else $error("period out of range");
  end

endmodule

// File: rtl/dco_zero_detect.sv
module dco_zero_detect #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] count,
  output logic             is_zero
);
  always_comb is_zero = (count == '0);
endmodule

// File: rtl/dco_down_counter.sv
module dco_down_counter #(
  parameter int MOD_M = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= CNT_W'(MOD_M);
    else if (reload)
      count <= load_val;
    else
      count <= count - CNT_W'(1);
  end

  // R1: away from a reload the count moves down by exactly one
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> count == $past(count) - CNT_W'(1))
    else $error("count step wrong");

  // R6: a reload takes the value offered at that edge
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> count == $past(load_val))
    else $error("reload value wrong");

endmodule

// File: rtl/dco_square_out.sv
module dco_square_out #(
  parameter bit EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic sq
);
  generate
    if (EN) begin : g_sq
      logic sq_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          sq_q <= 1'b0;
        else if (tick)
          sq_q <= ~sq_q;
      end
      assign sq = sq_q;

      // R8: square output flips on a pulse edge and only then
      p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> sq != $past(sq))
        else $error("square did not toggle");
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sq))
        else $error("square changed without pulse");
    end else begin : g_nosq
      assign sq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dco_prog_period.sv
module dco_prog_period #(
  parameter int MOD_M     = 16,
  parameter int K_W       = 6,
  parameter bit SQUARE_EN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [K_W-1:0] ctrl_k,
  output logic                  pulse_o,
  output logic                  square_o
);
  import dco_pkg::*;

  localparam int CNT_W = count_width(MOD_M);

  // internal events brought out as named wires
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] next_period;
  logic [CNT_W-1:0] next_load;
  logic             at_zero;
  logic             clip_lo;
  logic             clip_hi;

  dco_reload_calc #(.MOD_M(MOD_M), .K_W(K_W), .CNT_W(CNT_W)) u_calc (
    .k_in    (ctrl_k),
    .period  (next_period),
    .load_val(next_load),
    .clip_lo (clip_lo),
    .clip_hi (clip_hi)
  );

  dco_zero_detect #(.CNT_W(CNT_W)) u_zero (
    .count  (count),
    .is_zero(at_zero)
  );

  dco_down_counter #(.MOD_M(MOD_M), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (at_zero),
    .load_val(next_load),
    .count   (count)
  );

  dco_square_out #(.EN(SQUARE_EN)) u_sq (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (at_zero),
    .sq   (square_o)
  );

  assign pulse_o = at_zero;

  // R2: a pulse whose next period is 2 or more lasts one cycle
  p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && next_period >= CNT_W'(2)) |=> !pulse_o)
    else $error("pulse wider than one cycle");

  // R5: a clamped-low reload keeps the pulse high
  p_clip_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && clip_lo) |=> pulse_o)
    else $error("period-1 pulse dropped");

  // R5: a clamped-high reload restarts at the top of the range
  p_clip_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && clip_hi) |=> count == CNT_W'(2 * MOD_M - 2))
    else $error("upper clamp wrong");

endmodule

// File: tb/tb_dco_prog_period.sv
module tb_dco_prog_period;
  localparam int M  = 16;
  localparam int KW = 6;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [KW-1:0] ctrl_k = '0;
  logic                 pulse_o;
  logic                 square_o;

  int checks = 0;
  int fails  = 0;

  dco_prog_period #(.MOD_M(M), .K_W(KW), .SQUARE_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_k(ctrl_k),
    .pulse_o(pulse_o), .square_o(square_o)
  );

  always #4 clk = ~clk;

  function automatic int exp_period(input int k);
    int p;
    p = M - k;
    if (p < 1) p = 1;
    if (p > 2 * M - 1) p = 2 * M - 1;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Called at a negedge with pulse_o high. Sets k0, optionally switches
  // to k1 after mid edges, counts edges to the next pulse.
  task automatic measure(input int k0, input int k1, input int mid, input int expv,
                         input string req);
    int  n;
    bit  sq0;
    bit  wide_ok;
    sq0     = square_o;
    wide_ok = 1'b1;
    ctrl_k  = KW'(k0);
    n = 0;
    for (int i = 0; i < 4 * M; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (mid > 0 && n == mid) ctrl_k = KW'(k1);
      if (n == 1 && expv >= 2 && pulse_o) wide_ok = 1'b0;
      if (pulse_o) break;
    end
    // R3 / R1: edge count between pulses
    check(n == expv, req, n, expv);
    // R2: pulse dropped after one cycle when period >= 2
    check(wide_ok, "R2 one-wide", int'(wide_ok), 1);
    // R8: exactly one toggle across the interval
    check(square_o == !sq0, "R8 square toggle", int'(square_o), int'(!sq0));
  endtask

  initial begin
    int n;
    // R7: reset state
    rst_n  = 1'b0;
    ctrl_k = '0;
    repeat (3) @(negedge clk);
    check(pulse_o == 1'b0, "R7 reset pulse", int'(pulse_o), 0);
    check(square_o == 1'b0, "R7 reset square", int'(square_o), 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 4 * M; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (pulse_o) break;
    end
    check(n == M, "R7 first period", n, M);

    // R3, R4, R5: sweep every control value
    for (int k = -(1 << (KW - 1)); k < (1 << (KW - 1)); k++) begin
      if (k == 0)
        measure(k, k, 0, exp_period(k), "R4 free-running period");
      else if (M - k < 1 || M - k > 2 * M - 1)
        measure(k, k, 0, exp_period(k), "R5 clamped period");
      else
        measure(k, k, 0, exp_period(k), "R3 period M-K");
    end

    // R6: change mid-period; running period unaffected, next uses new K
    measure(0, 10, 5, M, "R6 mid-period change ignored");
    measure(10, 10, 0, M - 10, "R6 new K next period");
    measure(-7, 3, 2, M + 7, "R6 mid change negative K");
    measure(3, 3, 0, M - 3, "R6 next period after change");

    // R5: period 1 keeps pulse high continuously
    measure(20, 20, 0, 1, "R5 period one");
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(pulse_o == 1'b1, "R5 pulse held high", int'(pulse_o), 1);
    end

    // R7: reset mid-run
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(square_o == 1'b0, "R7 reset clears square", int'(square_o), 0);
    check(pulse_o == 1'b0, "R7 reset clears pulse", int'(pulse_o), 0);
    ctrl_k = 7'sd0 + KW'(12);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 4 * M; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (pulse_o) break;
    end
    check(n == M, "R7 first period ignores K", n, M);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule